// File: doc/BRIEF.md
# Widening Multiply-by-Scalar Vector Unit

This block performs one widening integer vector operation in which every element of a 64-bit source vector is multiplied by the same scalar. The scalar is a single lane taken from a 128-bit register. Each product is twice as wide as its source element, so the 128-bit result holds either four 32-bit lanes or two 64-bit lanes. The product can be written out on its own, added to the matching lane of a 128-bit accumulator, or subtracted from it. All arithmetic wraps, with no saturation and no flags.

The surrounding register file is outside the block. The unit computes which register holds the scalar from the raw scalar register field and presents that number on an output. The register file returns the contents of that register in the same cycle. The unit then picks the scalar lane using an index built by shuffling bits of the same field together with a separate extension bit.

Encodings the operation does not allow raise an undefined flag instead of producing a result. Results and flags are registered and appear one cycle after the input strobe.

Top module: `wms_top`

## Requirements
- R1: `size_sel`=01 selects 16-bit source elements, giving four 32-bit results. `size_sel`=10 selects 32-bit elements, giving two 64-bit results. Source element k is `src_vec[k*E +: E]`, and its result and accumulator lane are bits `[k*2E +: 2E]`.
- R2: `size_sel` values 00 and 11 are undefined. An undefined request raises `undef_flag` one cycle after `in_valid`, and `out_valid` stays low.
- R3: An odd destination register number (`dst_lsb`=1) is undefined in the same way, whatever the other inputs are.
- R4: `scal_reg_idx` is combinational. With 16-bit elements it is `{0, scal_field[2:1]}`. With 32-bit elements it is `scal_field[3:1]`.
- R5: A raw index is formed as {`scal_field[0]`, `m_bit`, `scal_field[3]`}, with the first bit most significant. With 16-bit elements the scalar is 16-bit lane `raw` of `scal_reg`. With 32-bit elements it is 32-bit lane `raw>>1`.
- R6: `is_unsigned`=1 zero-extends both the source elements and the scalar to double width. `is_unsigned`=0 sign-extends both.
- R7: `op_sel` selects the operation: 00 outputs the product, 01 outputs the accumulator lane plus the product, 10 outputs the accumulator lane minus the product. 11 is undefined (see R2).
- R8: Accumulate and subtract wrap modulo 2^(2E).
- R9: For a defined request, `out_vec` and `out_valid`=1 appear on the clock edge after the one that samples `in_valid`. `out_valid` lasts one cycle per strobe.
- R10: After synchronous reset, `out_valid`=0, `undef_flag`=0 and `out_vec`=0.
- R11: `out_vec` keeps its value whenever `out_valid` is low, including after an undefined request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| is_unsigned | input | 1 | 1: zero-extend operands, 0: sign-extend them |
| size_sel | input | 2 | Element size code |
| op_sel | input | 2 | Operation select |
| scal_field | input | 4 | Raw scalar register field |
| m_bit | input | 1 | Scalar extension bit |
| dst_lsb | input | 1 | Low bit of the destination register number |
| src_vec | input | 64 | Source vector |
| scal_reg | input | 128 | Contents of the register named by `scal_reg_idx` |
| acc_vec | input | 128 | Accumulator vector |
| scal_reg_idx | output | 3 | Number of the register that holds the scalar |
| out_valid | output | 1 | Result valid |
| undef_flag | output | 1 | Undefined encoding seen |
| out_vec | output | 128 | Widened result vector |

## Verification
The assertions check the following on every cycle:
- `out_valid` and `undef_flag` are never high together.
- A result only follows a strobe.
- The output vector holds while it is not valid.
- Odd destinations and illegal sizes always lead to the undefined flag.
- The register number stays inside four registers for 16-bit elements.

Only the bench's sweeps can show that the lane arithmetic is right. It checks the register and lane shuffle, sign and zero extension, accumulate and subtract with wrap-around, and the lane layout, across every scalar field value, both `m_bit` values, both sizes, both signedness settings and all three operations.

// File: rtl/wms_pkg.sv
package wms_pkg;
  typedef enum logic [1:0] {
    OP_MUL = 2'b00,
    OP_ACC = 2'b01,
    OP_SUB = 2'b10,
    OP_RSV = 2'b11
  } wms_op_e;

  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
endpackage

// File: rtl/wms_decode.sv
module wms_decode
  import wms_pkg::*;
(
  input  logic [1:0] size_sel,
  input  wms_op_e    op,
  input  logic       dst_lsb,
  input  logic [3:0] scal_field,
  input  logic       m_bit,
  output logic       undef,
  output logic       half_mode,
  output logic [2:0] reg_idx,
  output logic [2:0] lane_idx
);
  logic [2:0] raw_idx;
  logic       size_ok;

  always_comb begin
    raw_idx   = {scal_field[0], m_bit, scal_field[3]};
    half_mode = (size_sel == SZ_HALF);
    size_ok   = half_mode || (size_sel == SZ_WORD);
    if (half_mode) begin
      reg_idx  = {1'b0, scal_field[2:1]};
      lane_idx = raw_idx;
    end else begin
      reg_idx  = scal_field[3:1];
      lane_idx = {1'b0, raw_idx[2:1]};
    end
    undef = !size_ok || dst_lsb || (op == OP_RSV);
  end
endmodule

// File: rtl/wms_scalar_pick.sv
module wms_scalar_pick #(
  parameter int REG_W = 128
) (
  input  logic [REG_W-1:0] reg_data,
  input  logic [2:0]       lane_idx,
  output logic [15:0]      s_half,
  output logic [31:0]      s_word
);
  localparam int NH = REG_W / 16;
  localparam int NW = REG_W / 32;
  localparam int HB = $clog2(NH);
  localparam int WB = $clog2(NW);

  logic [15:0] half_arr [NH];
  logic [31:0] word_arr [NW];

  for (genvar i = 0; i < NH; i++) begin : g_half
    assign half_arr[i] = reg_data[i*16 +: 16];
  end
  for (genvar j = 0; j < NW; j++) begin : g_word
    assign word_arr[j] = reg_data[j*32 +: 32];
  end

  assign s_half = half_arr[lane_idx[HB-1:0]];
  assign s_word = word_arr[lane_idx[WB-1:0]];
endmodule

// File: rtl/wms_lane_alu.sv
module wms_lane_alu
  import wms_pkg::*;
#(
  parameter int EW = 16
) (
  input  logic [EW-1:0]   a,
  input  logic [EW-1:0]   b,
  input  logic [2*EW-1:0] acc,
  input  logic            is_unsigned,
  input  wms_op_e         op,
  output logic [2*EW-1:0] res
);
  logic [2*EW-1:0] ax, bx, prod;

  always_comb begin
    ax   = is_unsigned ? {{EW{1'b0}}, a} : {{EW{a[EW-1]}}, a};
    bx   = is_unsigned ? {{EW{1'b0}}, b} : {{EW{b[EW-1]}}, b};
    prod = ax * bx;
    unique case (op)
      OP_ACC:  res = acc + prod;
      OP_SUB:  res = acc - prod;
      default: res = prod;
    endcase
  end
endmodule

// File: rtl/wms_top.sv
module wms_top
  import wms_pkg::*;
#(
  parameter int SRC_W = 64,
  parameter int REG_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             is_unsigned,
  input  logic [1:0]       size_sel,
  input  logic [1:0]       op_sel,
  input  logic [3:0]       scal_field,
  input  logic             m_bit,
  input  logic             dst_lsb,
  input  logic [SRC_W-1:0] src_vec,
  input  logic [REG_W-1:0] scal_reg,
  input  logic [REG_W-1:0] acc_vec,
  output logic [2:0]       scal_reg_idx,
  output logic             out_valid,
  output logic             undef_flag,
  output logic [REG_W-1:0] out_vec
);
  localparam int NLH = SRC_W / 16;
  localparam int NLW = SRC_W / 32;

  wms_op_e    op;
  logic       undef, half_mode;
  logic [2:0] lane_idx;
  logic [15:0] s_half;
  logic [31:0] s_word;
  logic [REG_W-1:0] res_h, res_w;

  assign op = wms_op_e'(op_sel);

  wms_decode u_dec (
    .size_sel  (size_sel),
    .op        (op),
    .dst_lsb   (dst_lsb),
    .scal_field(scal_field),
    .m_bit     (m_bit),
    .undef     (undef),
    .half_mode (half_mode),
    .reg_idx   (scal_reg_idx),
    .lane_idx  (lane_idx)
  );

  wms_scalar_pick #(.REG_W(REG_W)) u_pick (
    .reg_data(scal_reg),
    .lane_idx(lane_idx),
    .s_half  (s_half),
    .s_word  (s_word)
  );

  for (genvar k = 0; k < NLH; k++) begin : g_hl
    wms_lane_alu #(.EW(16)) u_alu (
      .a          (src_vec[k*16 +: 16]),
      .b          (s_half),
      .acc        (acc_vec[k*32 +: 32]),
      .is_unsigned(is_unsigned),
      .op         (op),
      .res        (res_h[k*32 +: 32])
    );
  end

  for (genvar k = 0; k < NLW; k++) begin : g_wl
    wms_lane_alu #(.EW(32)) u_alu (
      .a          (src_vec[k*32 +: 32]),
      .b          (s_word),
      .acc        (acc_vec[k*64 +: 64]),
      .is_unsigned(is_unsigned),
      .op         (op),
      .res        (res_w[k*64 +: 64])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      undef_flag <= 1'b0;
      out_vec    <= '0;
    end else begin
      out_valid  <= in_valid && !undef;
      undef_flag <= in_valid && undef;
      if (in_valid && !undef)
        out_vec <= half_mode ? res_h : res_w;
    end
  end

  // R2 / R9: a result and an undefined flag never appear together
  p_flag_excl_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_valid, undef_flag}));

  // R9: a valid result only follows a strobe
  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R11: the output vector holds while no result is presented
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_vec));

  // R3: an odd destination always ends as undefined
  p_dst_odd_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dst_lsb) |=> (undef_flag && !out_valid));

  // R2: illegal sizes always end as undefined
  p_bad_size_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (size_sel == 2'b00 || size_sel == 2'b11)) |=> undef_flag);

  // R4: 16-bit mode reaches only the first four registers
  p_reg_range_r4: assert property (@(posedge clk) disable iff (rst)
    (size_sel == SZ_HALF) |-> !scal_reg_idx[2]);
endmodule

// File: tb/sim_wms_top.sv
module sim_wms_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         is_unsigned = 1'b0;
  logic [1:0]   size_sel = 2'b01;
  logic [1:0]   op_sel = 2'b00;
  logic [3:0]   scal_field = '0;
  logic         m_bit = 1'b0;
  logic         dst_lsb = 1'b0;
  logic [63:0]  src_vec = '0;
  logic [127:0] scal_reg;
  logic [127:0] acc_vec = '0;
  logic [2:0]   scal_reg_idx;
  logic         out_valid, undef_flag;
  logic [127:0] out_vec;

  logic [127:0] regs [8];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  always_comb scal_reg = regs[scal_reg_idx];

  wms_top u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .is_unsigned(is_unsigned),
    .size_sel(size_sel), .op_sel(op_sel), .scal_field(scal_field),
    .m_bit(m_bit), .dst_lsb(dst_lsb), .src_vec(src_vec), .scal_reg(scal_reg),
    .acc_vec(acc_vec), .scal_reg_idx(scal_reg_idx), .out_valid(out_valid),
    .undef_flag(undef_flag), .out_vec(out_vec)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] ref_vec(input int sz, input bit u, input int op,
      input logic [63:0] s, input logic [127:0] r, input logic [127:0] acc, input int lane);
    logic [127:0] v;
    v = '0;
    if (sz == 1) begin
      for (int k = 0; k < 4; k++) begin
        logic [15:0] a, b;
        logic [31:0] ax, bx, p, q;
        a = s[k*16 +: 16];
        b = r[lane*16 +: 16];
        ax = u ? {16'b0, a} : {{16{a[15]}}, a};
        bx = u ? {16'b0, b} : {{16{b[15]}}, b};
        p = ax * bx;
        q = (op == 0) ? p : (op == 1) ? acc[k*32 +: 32] + p : acc[k*32 +: 32] - p;
        v[k*32 +: 32] = q;
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        logic [31:0] a, b;
        logic [63:0] ax, bx, p, q;
        a = s[k*32 +: 32];
        b = r[lane*32 +: 32];
        ax = u ? {32'b0, a} : {{32{a[31]}}, a};
        bx = u ? {32'b0, b} : {{32{b[31]}}, b};
        p = ax * bx;
        q = (op == 0) ? p : (op == 1) ? acc[k*64 +: 64] + p : acc[k*64 +: 64] - p;
        v[k*64 +: 64] = q;
      end
    end
    return v;
  endfunction

  // one defined request: drive at negedge, check index at once, result one edge later
  task automatic run_ok(input int sz, input bit u, input int op, input int vm, input bit m);
    logic [2:0] raw, exp_reg;
    int lane;
    logic [127:0] exp;
    size_sel = sz[1:0]; is_unsigned = u; op_sel = op[1:0];
    scal_field = vm[3:0]; m_bit = m; dst_lsb = 1'b0;
    seed = nxt(seed); src_vec[31:0] = seed;
    seed = nxt(seed); src_vec[63:32] = seed;
    for (int w = 0; w < 4; w++) begin seed = nxt(seed); acc_vec[w*32 +: 32] = seed; end
    in_valid = 1'b1;
    raw = {scal_field[0], m, scal_field[3]};
    exp_reg = (sz == 1) ? {1'b0, scal_field[2:1]} : scal_field[3:1];
    lane = (sz == 1) ? int'(raw) : int'(raw >> 1);
    #1;
    chk(scal_reg_idx == exp_reg, "R4 register select", 128'(scal_reg_idx), 128'(exp_reg));
    exp = ref_vec(sz, u, op, src_vec, regs[exp_reg], acc_vec, lane);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && !undef_flag, "R9 valid one cycle later", 128'(out_valid), 128'(1));
    chk(out_vec == exp, "R1 R5 R6 R7 lane results", out_vec, exp);
  endtask

  // one undefined request: flag raised, no valid, output unchanged
  task automatic run_bad(input int sz, input int op, input bit dl, input string tag);
    logic [127:0] prev;
    prev = out_vec;
    size_sel = sz[1:0]; op_sel = op[1:0]; dst_lsb = dl; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(undef_flag && !out_valid, tag, 128'({undef_flag, out_valid}), 128'(2'b10));
    chk(out_vec == prev, "R11 output unchanged after undefined", out_vec, prev);
    dst_lsb = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++)
      for (int w = 0; w < 4; w++) begin
        seed = nxt(seed);
        regs[i][w*32 +: 32] = seed;
      end
    repeat (3) @(negedge clk);
    chk(!out_valid && !undef_flag && out_vec == '0, "R10 reset state",
        out_vec, '0);
    rst = 1'b0;
    @(negedge clk);

    // exhaustive sweep over sizes, signedness, ops, fields
    for (int sz = 1; sz <= 2; sz++)
      for (int u = 0; u < 2; u++)
        for (int op = 0; op < 3; op++)
          for (int vm = 0; vm < 16; vm++)
            for (int m = 0; m < 2; m++)
              run_ok(sz, u[0], op, vm, m[0]);

    // R9: no further valid without a strobe
    @(negedge clk);
    chk(!out_valid, "R9 single-cycle valid", 128'(out_valid), 128'(0));
    chk($isunknown(out_vec) == 0, "R11 held result", out_vec, out_vec);

    // R8: wrap-around on accumulate, unsigned 32-bit
    regs[1] = {128{1'b1}};
    src_vec = {64{1'b1}};
    size_sel = 2'b10; is_unsigned = 1'b1; op_sel = 2'b01;
    scal_field = 4'b0010; m_bit = 1'b0; dst_lsb = 1'b0;
    acc_vec = {128{1'b1}};
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_vec == {2{64'hFFFF_FFFE_0000_0000}}, "R8 accumulate wraps",
        out_vec, {2{64'hFFFF_FFFE_0000_0000}});
    // R8: subtract wraps below zero, signed 16-bit: 0 - (-1 * 1)... use 0 - 1*1
    regs[0] = 128'h1;
    src_vec = {4{16'h0001}};
    size_sel = 2'b01; is_unsigned = 1'b0; op_sel = 2'b10;
    scal_field = 4'b0000; m_bit = 1'b0;
    acc_vec = '0;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_vec == {4{32'hFFFF_FFFF}}, "R8 subtract wraps", out_vec, {4{32'hFFFF_FFFF}});
    // R6: signed -1 * -1 vs unsigned 0xFFFF * 0xFFFF
    regs[0] = {8{16'hFFFF}};
    src_vec = {4{16'hFFFF}};
    op_sel = 2'b00; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_vec == {4{32'h0000_0001}}, "R6 sign-extended product", out_vec, {4{32'h0000_0001}});
    is_unsigned = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_vec == {4{32'hFFFE_0001}}, "R6 zero-extended product", out_vec, {4{32'hFFFE_0001}});

    // undefined encodings
    run_bad(0, 0, 1'b0, "R2 size 00 undefined");
    run_bad(3, 0, 1'b0, "R2 size 11 undefined");
    run_bad(1, 0, 1'b1, "R3 odd destination 16-bit");
    run_bad(2, 1, 1'b1, "R3 odd destination 32-bit");
    run_bad(2, 3, 1'b0, "R7 op 11 undefined");
    @(negedge clk);
    chk(!undef_flag && !out_valid, "R2 flag clears without strobe",
        128'({undef_flag, out_valid}), 128'(0));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule